// File: doc/BRIEF.md
# Oscillator Clock Quality Checker

This block decides whether an external oscillator clock is present and stable enough to be trusted. It runs entirely in a free-running reference clock domain, which in a real system is the PLL in its self-clock-mode state. The oscillator is sampled as data through a synchronizer. Each synchronized rising edge becomes a one-cycle pulse.

Two mechanisms work together. A coarse missing-edge watchdog reports a monitor failure when no oscillator edge arrives within a timeout. A finer qualifier opens check windows of fixed length, counted in reference cycles, and counts oscillator edges inside each window. The qualifier declares the oscillator good as soon as the edge count reaches a threshold, which can be before the window ends. A check starts on a power-on event, a low-voltage reset event, a wake from full stop, or a monitor failure. On a monitor failure, a control input decides whether the block requests self-clock mode or a system reset.

Top module: `osc_quality_checker`

## Requirements
- R1: While reset is held and right after it is released, mon_fail_o, osc_ok_o, chk_busy_o, scm_req_o and rst_req_o are all low.
- R2: With mon_en_i high, if TIMEOUT_CYCLES reference cycles pass with no synchronized oscillator rising edge, mon_fail_o pulses high for exactly one cycle.
- R3: While mon_en_i is low, mon_fail_o never goes high, whatever the oscillator does.
- R4: While oscillator rising edges arrive less than TIMEOUT_CYCLES reference cycles apart, no monitor failure is reported.
- R5: When a monitor failure occurs with scm_en_i high, scm_req_o goes high on the next cycle and rst_req_o stays low.
- R6: When a monitor failure occurs with scm_en_i low, rst_req_o pulses high for one cycle on the next cycle and scm_req_o does not rise.
- R7: Any of trig_por_i, trig_lvr_i, trig_wake_i or a monitor failure starts a new check. On the next cycle chk_busy_o is high and osc_ok_o is low.
- R8: When EDGE_THRESHOLD oscillator rising edges are counted within one window, the check ends at once, before WINDOW_CYCLES elapse. osc_ok_o then rises and chk_busy_o falls.
- R9: A window that expires below the threshold leaves osc_ok_o low and chk_busy_o high. A fresh window then starts with its edge count at zero, so edges do not carry over between windows.
- R10: One cycle after a check passes, scm_req_o is low.
- R11: Once set, osc_ok_o stays high until the next check is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock (self-clock-mode rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk_i | input | 1 | Oscillator clock, sampled as asynchronous data |
| trig_por_i | input | 1 | Power-on event, one-cycle pulse, starts a check |
| trig_lvr_i | input | 1 | Low-voltage reset event, starts a check |
| trig_wake_i | input | 1 | Wake-from-full-stop event, starts a check |
| mon_en_i | input | 1 | Enables the missing-edge watchdog |
| scm_en_i | input | 1 | 1: a monitor failure requests self-clock mode; 0: it requests reset |
| mon_fail_o | output | 1 | One-cycle monitor failure pulse |
| osc_ok_o | output | 1 | Oscillator has passed a quality check |
| chk_busy_o | output | 1 | A quality check is in progress |
| scm_req_o | output | 1 | Self-clock-mode request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with a 64-cycle window, an 8-edge threshold and a 16-cycle timeout. With these values, a pass, a failed window followed by a restart, and a watchdog failure each take only tens of cycles. An oscillator with a period of 12 reference cycles never trips the timeout, but it supplies only five or six edges per window. This is below the threshold in any single window but above it across two windows, so any carry-over of the edge count between windows makes the check pass when it should not. An oscillator with a period of 4 reference cycles passes well before the window ends, which shows that the check ends early.

// File: rtl/oscq_pkg.sv
package oscq_pkg;

   // Action taken on a monitor failure, chosen by the self-clock enable
   typedef enum logic [1:0] {
      FAIL_ACT_NONE  = 2'd0,
      FAIL_ACT_SCM   = 2'd1,
      FAIL_ACT_RESET = 2'd2
   } fail_act_e;

   function automatic fail_act_e decode_fail(input logic fail, input logic scm_en);
      if (!fail)      return FAIL_ACT_NONE;
      else if (scm_en) return FAIL_ACT_SCM;
      else            return FAIL_ACT_RESET;
   endfunction

endpackage

// File: rtl/oscq_edge_sync.sv
module oscq_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   // chain[0..STAGES-1] synchronize, chain[STAGES] holds previous sample
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_i};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/oscq_edge_watchdog.sv
module oscq_edge_watchdog #(
   parameter int TIMEOUT_CYCLES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic edge_i,
   output logic fail_o
);
   localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
   localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fail_o <= 1'b0;
      end else if (!en_i || edge_i) begin
         cnt_q  <= '0;
         fail_o <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q  <= '0;
         fail_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         fail_o <= 1'b0;
      end
   end
endmodule

// File: rtl/oscq_window_engine.sv
module oscq_window_engine #(
   parameter int WINDOW_CYCLES  = 50000,
   parameter int EDGE_THRESHOLD = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic edge_i,
   output logic busy_o,
   output logic ok_o,
   output logic pass_o
);
   localparam int WW = $clog2(WINDOW_CYCLES);
   localparam int CW = $clog2(EDGE_THRESHOLD + 1);
   localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYCLES - 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(EDGE_THRESHOLD - 1);

   logic [WW-1:0] win_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         cnt_q  <= '0;
         busy_o <= 1'b0;
         ok_o   <= 1'b0;
         pass_o <= 1'b0;
      end else begin
         pass_o <= 1'b0;
         if (start_i) begin
            busy_o <= 1'b1;
            ok_o   <= 1'b0;
            win_q  <= '0;
            cnt_q  <= '0;
         end else if (busy_o) begin
            if (edge_i && cnt_q == CNT_LAST) begin
               // threshold reached: window closes early
               busy_o <= 1'b0;
               ok_o   <= 1'b1;
               pass_o <= 1'b1;
            end else if (win_q == WIN_LAST) begin
               win_q <= '0;
               cnt_q <= '0;
            end else begin
               win_q <= win_q + 1'b1;
               if (edge_i) cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/osc_quality_checker.sv
module osc_quality_checker #(
   parameter int WINDOW_CYCLES  = 50000,
   parameter int EDGE_THRESHOLD = 4096,
   parameter int TIMEOUT_CYCLES = 128,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic osc_clk_i,
   input  logic trig_por_i,
   input  logic trig_lvr_i,
   input  logic trig_wake_i,
   input  logic mon_en_i,
   input  logic scm_en_i,
   output logic mon_fail_o,
   output logic osc_ok_o,
   output logic chk_busy_o,
   output logic scm_req_o,
   output logic rst_req_o
);
   import oscq_pkg::*;

   if (EDGE_THRESHOLD < 2) begin : g_bad_thr
      $error("EDGE_THRESHOLD must be at least 2");
   end
   if (WINDOW_CYCLES <= EDGE_THRESHOLD) begin : g_bad_win
      $error("WINDOW_CYCLES must exceed EDGE_THRESHOLD");
   end
   if (TIMEOUT_CYCLES < 2) begin : g_bad_to
      $error("TIMEOUT_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic      osc_rise;
   logic      fail;
   logic      start;
   logic      pass;
   fail_act_e act;

   oscq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .async_i(osc_clk_i),
      .rise_o (osc_rise)
   );

   oscq_edge_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wdog (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .en_i  (mon_en_i),
      .edge_i(osc_rise),
      .fail_o(fail)
   );

   assign start = trig_por_i | trig_lvr_i | trig_wake_i | fail;

   oscq_window_engine #(
      .WINDOW_CYCLES (WINDOW_CYCLES),
      .EDGE_THRESHOLD(EDGE_THRESHOLD)
   ) u_engine (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .start_i(start),
      .edge_i (osc_rise),
      .busy_o (chk_busy_o),
      .ok_o   (osc_ok_o),
      .pass_o (pass)
   );

   assign act = decode_fail(fail, scm_en_i);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         scm_req_o <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         rst_req_o <= (act == FAIL_ACT_RESET);
         if (act == FAIL_ACT_SCM) scm_req_o <= 1'b1;
         else if (pass)           scm_req_o <= 1'b0;
      end
   end

   assign mon_fail_o = fail;
endmodule

// File: rtl/oscq_checker.sv
module oscq_checker (
   input logic clk,
   input logic rst_n,
   input logic por,
   input logic lvr,
   input logic wake,
   input logic mon_en,
   input logic scm_en,
   input logic mon_fail,
   input logic osc_ok,
   input logic busy,
   input logic scm_req,
   input logic rst_req
);
   logic trig;
   assign trig = por | lvr | wake | mon_fail;

   a_r2_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
      mon_fail |=> !mon_fail);

   a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> !mon_fail);

   a_r5_scm_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_fail && scm_en) |=> (scm_req && !rst_req));

   a_r6_reset_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_fail && !scm_en) |=> rst_req);

   a_r6_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r7_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (busy && !osc_ok));

   a_r8_ok_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      osc_ok |-> !busy);

   a_r10_pass_drops_scm: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(osc_ok) && !mon_fail) |=> !scm_req);

   a_r11_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_ok && !trig) |=> osc_ok);
endmodule

bind osc_quality_checker oscq_checker u_oscq_checker (
   .clk     (clk_ref),
   .rst_n   (rst_n),
   .por     (trig_por_i),
   .lvr     (trig_lvr_i),
   .wake    (trig_wake_i),
   .mon_en  (mon_en_i),
   .scm_en  (scm_en_i),
   .mon_fail(mon_fail_o),
   .osc_ok  (osc_ok_o),
   .busy    (chk_busy_o),
   .scm_req (scm_req_o),
   .rst_req (rst_req_o)
);

// File: tb/osc_quality_checker_bench.sv
`timescale 1ns/100ps
module osc_quality_checker_bench;
   localparam int WIN = 64;
   localparam int THR = 8;
   localparam int TMO = 16;

   typedef enum int {EV_FAIL, EV_RST, EV_OK} ev_e;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc = 1'b0;
   logic por = 1'b0, lvr = 1'b0, wake = 1'b0;
   logic mon_en = 1'b0, scm_en = 1'b0;
   logic mon_fail, osc_ok, busy, scm_req, rst_req;

   int checks = 0;
   int failures = 0;
   int osc_half = 0;
   int fail_seen = 0;
   bit done = 1'b0;

   ev_e   exp_q[$];
   string exp_tag[$];

   always #2.5 clk = ~clk;

   osc_quality_checker #(
      .WINDOW_CYCLES(WIN), .EDGE_THRESHOLD(THR), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2)
   ) u_osc_quality_checker (
      .clk_ref(clk), .rst_n(rst_n), .osc_clk_i(osc),
      .trig_por_i(por), .trig_lvr_i(lvr), .trig_wake_i(wake),
      .mon_en_i(mon_en), .scm_en_i(scm_en),
      .mon_fail_o(mon_fail), .osc_ok_o(osc_ok), .chk_busy_o(busy),
      .scm_req_o(scm_req), .rst_req_o(rst_req)
   );

   // oscillator model: toggles every osc_half reference cycles, 0 = stopped
   initial begin
      int ph;
      ph = 0;
      forever begin
         @(posedge clk);
         if (osc_half != 0) begin
            ph++;
            if (ph >= osc_half) begin
               ph = 0;
               #1 osc = ~osc;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input ev_e k, input string tag);
      exp_q.push_back(k);
      exp_tag.push_back(tag);
   endtask

   task automatic observe(input ev_e k);
      ev_e   e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
         failures++;
         $display("FAIL R3/R4/R8 unexpected event actual=%0d expected=none", int'(k));
      end else begin
         e = exp_q.pop_front();
         t = exp_tag.pop_front();
         if (e != k) begin
            failures++;
            $display("FAIL %s event actual=%0d expected=%0d", t, int'(k), int'(e));
         end
      end
   endtask

   // monitor: pops the scoreboard on each output event, checks pulse widths
   logic fail_p = 1'b0, rst_p = 1'b0, ok_p = 1'b0;
   int fail_w = 0, rst_w = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mon_fail && !fail_p) begin
            fail_seen++;
            observe(EV_FAIL);
         end
         if (rst_req && !rst_p) observe(EV_RST);
         if (osc_ok && !ok_p) observe(EV_OK);
         if (mon_fail) fail_w++;
         else if (fail_w != 0) begin
            check(fail_w == 1, "R2 fail pulse width", fail_w, 1);
            fail_w = 0;
         end
         if (rst_req) rst_w++;
         else if (rst_w != 0) begin
            check(rst_w == 1, "R6 reset pulse width", rst_w, 1);
            rst_w = 0;
         end
      end
      fail_p = mon_fail;
      rst_p  = rst_req;
      ok_p   = osc_ok;
   end

   task automatic drive_pulse(input int which);
      @(posedge clk); #1;
      if (which == 0) por = 1'b1; else if (which == 1) lvr = 1'b1; else wake = 1'b1;
      @(posedge clk); #1;
      por = 1'b0; lvr = 1'b0; wake = 1'b0;
   endtask

   task automatic wait_ok(input int limit, output int cycles);
      cycles = 0;
      while (!osc_ok && cycles < limit) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic wait_fail(input int limit);
      int n;
      n = 0;
      while (!mon_fail && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int cyc;
      // R1: reset state
      repeat (3) @(negedge clk);
      check({mon_fail, osc_ok, busy, scm_req, rst_req} == 5'b0, "R1 during reset",
            {mon_fail, osc_ok, busy, scm_req, rst_req}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check({mon_fail, osc_ok, busy, scm_req, rst_req} == 5'b0, "R1 after release",
            {mon_fail, osc_ok, busy, scm_req, rst_req}, 0);

      // R3: watchdog off, oscillator stopped
      repeat (100) @(negedge clk);
      check(fail_seen == 0, "R3 no fail while disabled", fail_seen, 0);

      // R8: fast oscillator, power-on check passes early
      osc_half = 2;
      @(posedge clk); #1 mon_en = 1'b1;
      expect_ev(EV_OK, "R8");
      drive_pulse(0);
      @(negedge clk);
      check(busy && !osc_ok, "R7 por starts check", {busy, osc_ok}, 2);
      wait_ok(WIN, cyc);
      check(osc_ok && cyc < WIN - 1, "R8 early pass", cyc, WIN);
      check(!busy, "R8 busy drops", busy, 0);

      // R11 and R4: ok holds, edges keep watchdog quiet
      repeat (100) @(negedge clk);
      check(osc_ok, "R11 ok sticky", osc_ok, 1);
      check(fail_seen == 0, "R4 no fail with edges", fail_seen, 0);

      // R9: slow oscillator, never enough edges per window
      osc_half = 6;
      drive_pulse(1);
      @(negedge clk);
      check(busy && !osc_ok, "R7 lvr starts check", {busy, osc_ok}, 2);
      repeat (4 * WIN) @(negedge clk);
      check(busy && !osc_ok, "R9 no carry-over between windows", {busy, osc_ok}, 2);
      check(fail_seen == 0, "R4 slow edges within timeout", fail_seen, 0);
      drive_pulse(2);
      @(negedge clk);
      check(busy && !osc_ok, "R7 wake starts check", {busy, osc_ok}, 2);
      expect_ev(EV_OK, "R8");
      osc_half = 2;
      wait_ok(3 * WIN, cyc);
      check(osc_ok && !busy, "R8 pass after speed-up", osc_ok, 1);

      // R5, R7, R10: failure with self-clock mode selected
      scm_en = 1'b1;
      expect_ev(EV_FAIL, "R2");
      expect_ev(EV_OK, "R10");
      osc_half = 0;
      wait_fail(4 * TMO);
      check(mon_fail, "R2 fail after timeout", mon_fail, 1);
      @(posedge clk); #1 mon_en = 1'b0;
      @(negedge clk);
      check(scm_req && !rst_req, "R5 scm requested", {scm_req, rst_req}, 2);
      check(busy && !osc_ok, "R7 fail starts check", {busy, osc_ok}, 2);
      osc_half = 2;
      wait_ok(3 * WIN, cyc);
      check(osc_ok, "R10 recheck passes", osc_ok, 1);
      @(negedge clk);
      check(!scm_req, "R10 scm dropped", scm_req, 0);

      // R6: failure with reset selected
      scm_en = 1'b0;
      @(posedge clk); #1 mon_en = 1'b1;
      expect_ev(EV_FAIL, "R2");
      expect_ev(EV_RST, "R6");
      osc_half = 0;
      wait_fail(4 * TMO);
      check(mon_fail, "R2 fail after timeout", mon_fail, 1);
      @(posedge clk); #1 mon_en = 1'b0;
      @(negedge clk);
      check(rst_req && !scm_req, "R6 reset requested", {rst_req, scm_req}, 2);
      repeat (40) @(negedge clk);
      check(!scm_req, "R6 scm stays low", scm_req, 0);
      check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule